// File: doc/BRIEF.md
# Orbit Marker Source Selector and Delay

This block runs on a trigger board and generates the start-of-orbit marker that the board passes up to a merging board. The marker comes from one of two places: a bunch-crossing counter inside the block, which wraps once per orbit, or a marker relayed in from a front-end card. The board's own counter is the preferred source. However, the select register comes out of reset set to relay, so configuration has to switch it over.

The chosen marker travels through a delay line together with the level-1 accept and the other timing command strobes. The line adds 0 to DEPTH-1 bunch crossings, so the commands sent toward the front-end card keep the same timing relationship with the marker. A per-board mask stops the marker at the entry to the delay line. This allows boards to be enabled one at a time when looking for a board that is out of alignment.

The source select and the delay setting are sampled only in the last crossing of each local orbit. A change made in the middle of an orbit therefore can never duplicate or drop a marker.

Top module: `orbit_mark_delay`

## Requirements
- R1: While rst_n is low, merge_mark_o, fe_l1a_o and fe_cmd_o are all zero.
- R2: In local mode (source 0) with delay d, the internal counter wraps once every ORBIT_LEN cycles. merge_mark_o is then high for exactly one cycle after clock edges ORBIT_LEN+d, 2*ORBIT_LEN+d, and so on, counting edges from reset release.
- R3: The source register resets to relay (1). Until the first local wrap, a fe_mark_i pulse is forwarded whatever value cfg_relay_i holds. The delay in effect after reset is 0.
- R4: In relay mode (cfg_relay_i = 1), a fe_mark_i pulse that is present at clock edge e appears on merge_mark_o after edge e+d, and local wraps never reach the output. In local mode, fe_mark_i pulses are ignored.
- R5: cfg_relay_i and cfg_delay_i are sampled only in the cycle where the local counter sits at ORBIT_LEN-1. At any other time, changing them has no effect on the output until that cycle.
- R6: l1a_i and cmd_i present at edge e appear on fe_l1a_o and fe_cmd_o after edge e+d. This is the same latency as the marker, for every d from 0 to DEPTH-1.
- R7: While cfg_mask_i is 1, merge_mark_o stays low, and l1a_i and cmd_i still pass through unchanged. The mask is sampled at the entry of the delay line.
- R8: When the delay is changed from d_old to d_new, one marker per orbit is still emitted: after edge ORBIT_LEN+d_old, then after edge 2*ORBIT_LEN+d_new, with no extra marker and no missing marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_mark_i | input | 1 | Orbit marker relayed from the front-end card |
| l1a_i | input | 1 | Level-1 accept strobe to forward |
| cmd_i | input | CMD_W | Timing command strobes to forward |
| cfg_relay_i | input | 1 | Source select: 1 relays fe_mark_i, 0 uses the local counter |
| cfg_delay_i | input | $clog2(DEPTH) | Delay in bunch crossings |
| cfg_mask_i | input | 1 | 1 suppresses the marker |
| merge_mark_o | output | 1 | Delayed orbit marker toward the merging board |
| fe_l1a_o | output | 1 | Delayed level-1 accept toward the front end |
| fe_cmd_o | output | CMD_W | Delayed command strobes toward the front end |

## Verification
If the orbit counter is off by one, the marker lands a crossing early or late, and this shows at the port within the first orbit. Each delay setting is swept while every cycle is compared, so a wrong tap or a wrong latch timing is caught within DEPTH cycles of the first stimulus. A select or delay register that updates outside the orbit boundary shows up as a marker that is missing or doubled. It can also show up as a command strobe that comes out with the new latency before the boundary. Both of these are visible within one orbit of the mid-orbit change.

// File: rtl/omd_pkg.sv
package omd_pkg;
   typedef enum logic {
      SRC_LOCAL = 1'b0,
      SRC_RELAY = 1'b1
   } omd_src_e;

   localparam int unsigned OMD_ORBIT_BX = 3564;
endpackage

// File: rtl/omd_orbit_cnt.sv
module omd_orbit_cnt #(
   parameter int unsigned ORBIT_LEN = 3564
) (
   input  logic clk,
   input  logic rst_n,
   output logic wrap_o
);
   localparam int unsigned CNT_W = $clog2(ORBIT_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_LEN - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign wrap_o = (cnt_q == LAST);
endmodule

// File: rtl/omd_cfg_latch.sv
module omd_cfg_latch
   import omd_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  omd_src_e         cfg_src_i,
   input  logic [DLY_W-1:0] cfg_dly_i,
   output omd_src_e         src_q_o,
   output omd_src_e         src_now_o,
   output logic [DLY_W-1:0] dly_q_o
);
   // Settings move only at the orbit boundary; the marker captured in that
   // same cycle already follows the new source.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q_o <= SRC_RELAY;
         dly_q_o <= '0;
      end else if (boundary_i) begin
         src_q_o <= cfg_src_i;
         dly_q_o <= cfg_dly_i;
      end
   end

   assign src_now_o = boundary_i ? cfg_src_i : src_q_o;
endmodule

// File: rtl/omd_delay_line.sv
module omd_delay_line #(
   parameter int unsigned W     = 5,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     in_vec,
   input  logic [SEL_W-1:0] sel_i,
   output logic [W-1:0]     head_o,
   output logic [W-1:0]     out_vec
);
   logic [DEPTH-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= in_vec;
         for (int k = 1; k < DEPTH; k++)
            stage_q[k] <= stage_q[k-1];
      end
   end

   assign head_o  = stage_q[0];
   assign out_vec = stage_q[sel_i];
endmodule

// File: rtl/orbit_mark_delay.sv
module orbit_mark_delay
   import omd_pkg::*;
#(
   parameter int unsigned ORBIT_LEN = OMD_ORBIT_BX,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned CMD_W     = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fe_mark_i,
   input  logic                     l1a_i,
   input  logic [CMD_W-1:0]         cmd_i,
   input  logic                     cfg_relay_i,
   input  logic [$clog2(DEPTH)-1:0] cfg_delay_i,
   input  logic                     cfg_mask_i,
   output logic                     merge_mark_o,
   output logic                     fe_l1a_o,
   output logic [CMD_W-1:0]         fe_cmd_o
);
   localparam int unsigned DLY_W    = $clog2(DEPTH);
   localparam int unsigned VEC_W    = CMD_W + 2;
   localparam int unsigned MARK_BIT = VEC_W - 1;
   localparam int unsigned L1A_BIT  = CMD_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (ORBIT_LEN <= 2 * DEPTH) begin : g_bad_orbit
      $error("ORBIT_LEN must exceed twice DEPTH");
   end
   if (CMD_W < 1) begin : g_bad_cmd
      $error("CMD_W must be at least 1");
   end

   logic             loc_mark;
   omd_src_e         src_q;
   omd_src_e         src_now;
   logic [DLY_W-1:0] act_dly;
   logic             mark_sel;
   logic [VEC_W-1:0] entry_vec;
   logic [VEC_W-1:0] head_vec;
   logic [VEC_W-1:0] tap_vec;

   omd_orbit_cnt #(.ORBIT_LEN(ORBIT_LEN)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap_o (loc_mark)
   );

   omd_cfg_latch #(.DLY_W(DLY_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary_i (loc_mark),
      .cfg_src_i  (omd_src_e'(cfg_relay_i)),
      .cfg_dly_i  (cfg_delay_i),
      .src_q_o    (src_q),
      .src_now_o  (src_now),
      .dly_q_o    (act_dly)
   );

   assign mark_sel  = (src_now == SRC_RELAY) ? fe_mark_i : loc_mark;
   assign entry_vec = {mark_sel & ~cfg_mask_i, l1a_i, cmd_i};

   omd_delay_line #(.W(VEC_W), .DEPTH(DEPTH), .SEL_W(DLY_W)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vec  (entry_vec),
      .sel_i   (act_dly),
      .head_o  (head_vec),
      .out_vec (tap_vec)
   );

   assign merge_mark_o = tap_vec[MARK_BIT];
   assign fe_l1a_o     = tap_vec[L1A_BIT];
   assign fe_cmd_o     = tap_vec[CMD_W-1:0];
endmodule

// File: rtl/omd_checker.sv
module omd_checker
   import omd_pkg::*;
#(
   parameter int unsigned ORBIT_LEN = 3564,
   parameter int unsigned DLY_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             loc_mark,
   input omd_src_e         src_q,
   input logic [DLY_W-1:0] act_dly,
   input logic             head_mark,
   input logic             cfg_mask_i,
   input logic             l1a_i,
   input logic             fe_l1a_o
);
   localparam int unsigned GAP_W = $clog2(ORBIT_LEN);

   logic             armed;
   logic             seen;
   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         seen  <= 1'b0;
         gap   <= '0;
      end else begin
         armed <= 1'b1;
         if (loc_mark) begin
            seen <= 1'b1;
            gap  <= '0;
         end else begin
            gap <= gap + 1'b1;
         end
      end
   end

   p_orbit_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_mark && seen) |-> (gap == GAP_W'(ORBIT_LEN - 1)));

   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_mark |=> ($stable(act_dly) && $stable(src_q)));

   p_src_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (src_q == SRC_RELAY));

   p_mask_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(cfg_mask_i)) |-> !head_mark);

   p_zero_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && act_dly == '0) |-> (fe_l1a_o == $past(l1a_i)));
endmodule

bind orbit_mark_delay omd_checker #(.ORBIT_LEN(ORBIT_LEN), .DLY_W(DLY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .loc_mark   (loc_mark),
   .src_q      (src_q),
   .act_dly    (act_dly),
   .head_mark  (head_vec[MARK_BIT]),
   .cfg_mask_i (cfg_mask_i),
   .l1a_i      (l1a_i),
   .fe_l1a_o   (fe_l1a_o)
);

// File: tb/orbit_mark_delay_test.sv
module orbit_mark_delay_test;
   localparam int L          = 40;
   localparam int DEPTH      = 16;
   localparam int CW         = 3;
   localparam int NC         = 256;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          rst_n;
   logic          fe_mark;
   logic          l1a;
   logic [CW-1:0] cmd;
   logic          relay;
   logic [3:0]    dly;
   logic          mask;
   logic          mark_o;
   logic          l1a_o;
   logic [CW-1:0] cmd_o;

   orbit_mark_delay #(.ORBIT_LEN(L), .DEPTH(DEPTH), .CMD_W(CW)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .fe_mark_i    (fe_mark),
      .l1a_i        (l1a),
      .cmd_i        (cmd),
      .cfg_relay_i  (relay),
      .cfg_delay_i  (dly),
      .cfg_mask_i   (mask),
      .merge_mark_o (mark_o),
      .fe_l1a_o     (l1a_o),
      .fe_cmd_o     (cmd_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   logic          drv_fe  [NC];
   logic          drv_l1a [NC];
   logic [CW-1:0] drv_cmd [NC];
   logic [3:0]    cfg_dly_a [NC];
   logic          cfg_rel_a [NC];
   logic          mask_a  [NC];
   logic          exp_mark[NC];
   logic          exp_l1a [NC];
   logic [CW-1:0] exp_cmd [NC];

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, got cyc=%0d expected < 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic clear_case(input logic [3:0] d, input logic rel, input logic m);
      for (int n = 0; n < NC; n++) begin
         drv_fe[n] = 1'b0; drv_l1a[n] = 1'b0; drv_cmd[n] = '0;
         cfg_dly_a[n] = d; cfg_rel_a[n] = rel; mask_a[n] = m;
         exp_mark[n] = 1'b0; exp_l1a[n] = 1'b0; exp_cmd[n] = '0;
      end
   endtask

   // R6: strobes driven in cycle n are expected after edge n+1+d
   task automatic cmd_pattern(input int first, input int last, input int d);
      for (int n = first; n <= last; n++) begin
         drv_l1a[n] = (n % 3 == 0);
         drv_cmd[n] = CW'((n * 5) % 8);
         exp_l1a[n + 1 + d] = drv_l1a[n];
         exp_cmd[n + 1 + d] = drv_cmd[n];
      end
   endtask

   task automatic check_out(input string req, input int n);
      checks = checks + 1;
      if (mark_o !== exp_mark[n] || l1a_o !== exp_l1a[n] || cmd_o !== exp_cmd[n]) begin
         errors = errors + 1;
         $display("FAIL %s edge %0d: got mark=%b l1a=%b cmd=%h expected mark=%b l1a=%b cmd=%h",
                  req, n, mark_o, l1a_o, cmd_o, exp_mark[n], exp_l1a[n], exp_cmd[n]);
      end
   endtask

   task automatic run_case(input string req, input int ncyc);
      rst_n = 1'b0; fe_mark = 1'b0; l1a = 1'b0; cmd = '0;
      dly = cfg_dly_a[0]; relay = cfg_rel_a[0]; mask = mask_a[0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks = checks + 1;   // R1 reset state
      if (mark_o !== 1'b0 || l1a_o !== 1'b0 || cmd_o !== '0) begin
         errors = errors + 1;
         $display("FAIL R1 in reset: got mark=%b l1a=%b cmd=%h expected 0 0 0", mark_o, l1a_o, cmd_o);
      end
      rst_n = 1'b1;
      for (int n = 0; n <= ncyc; n++) begin
         if (n >= 1) check_out(req, n);
         fe_mark = drv_fe[n]; l1a = drv_l1a[n]; cmd = drv_cmd[n];
         dly = cfg_dly_a[n]; relay = cfg_rel_a[n]; mask = mask_a[n];
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      // R2 R6: sweep every delay in local mode
      for (int d = 0; d < DEPTH; d++) begin
         clear_case(4'(d), 1'b0, 1'b0);
         for (int k = 1; k <= 3; k++) exp_mark[k * L + d] = 1'b1;
         cmd_pattern(L, 2 * L + 20, d);
         run_case("R2_R6 delay sweep", 3 * L + 16);
      end

      // R7: mask blocks the marker, strobes still pass
      clear_case(4'd5, 1'b0, 1'b1);
      cmd_pattern(L, 2 * L, 5);
      run_case("R7 mask", 3 * L);

      // R3: relay after reset, delay 0, until first wrap; then R4 local ignores fe
      clear_case(4'd7, 1'b0, 1'b0);
      drv_fe[3] = 1'b1;  exp_mark[4] = 1'b1;
      drv_fe[20] = 1'b1; exp_mark[21] = 1'b1;
      exp_mark[L + 7] = 1'b1; exp_mark[2 * L + 7] = 1'b1;
      drv_fe[L + 20] = 1'b1;
      run_case("R3_R4 reset relay", 2 * L + 10);

      // R4: relay mode, local wraps hidden
      clear_case(4'd3, 1'b1, 1'b0);
      drv_fe[10] = 1'b1;        exp_mark[11] = 1'b1;
      drv_fe[L + 5] = 1'b1;     exp_mark[L + 9] = 1'b1;
      drv_fe[L + 17] = 1'b1;    exp_mark[L + 21] = 1'b1;
      drv_fe[2 * L + 2] = 1'b1; exp_mark[2 * L + 6] = 1'b1;
      run_case("R4 relay", 3 * L);

      // R5 R8: delay changed mid orbit takes effect at next boundary
      clear_case(4'd2, 1'b0, 1'b0);
      for (int n = L + 10; n < NC; n++) cfg_dly_a[n] = 4'd9;
      exp_mark[L + 2] = 1'b1; exp_mark[2 * L + 9] = 1'b1; exp_mark[3 * L + 9] = 1'b1;
      drv_l1a[L + 12] = 1'b1;    exp_l1a[L + 15] = 1'b1;
      drv_l1a[2 * L + 3] = 1'b1; exp_l1a[2 * L + 13] = 1'b1;
      run_case("R5_R8 delay change", 3 * L + 12);

      // R5: source changed mid orbit takes effect at next boundary
      clear_case(4'd4, 1'b0, 1'b0);
      for (int n = L + 10; n < NC; n++) cfg_rel_a[n] = 1'b1;
      exp_mark[L + 4] = 1'b1;
      drv_fe[L + 15] = 1'b1;
      drv_fe[2 * L + 5] = 1'b1; exp_mark[2 * L + 10] = 1'b1;
      run_case("R5 source change", 3 * L);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule